// File: doc/BRIEF.md
# Dual-Clock Coincidence Sync Pulse Generator

This block divides one fast reference clock into two slower output clocks, `out_a` and `out_c`. Each has its own integer divide ratio. Beside them it drives an active-low warning strobe, `sync_n`, that marks the approach of the next rising edge the two clocks share. The two ratios do not need to be integer multiples of each other. Logic that has to line up data between the two output domains can use the strobe as a common frame marker.

The divide ratios are captured only while reset is asserted. After reset is released, a small iterative unit finds the least common multiple (LCM) of the two ratios. During this search all outputs stay in their idle state. When the search finishes, both divided clocks rise together and a master counter starts to run modulo the LCM.

The strobe is timed by the faster output clock. It drops one fast-clock period before the shared rising edge and rises again on that edge. A strobe is produced for every ratio pair, including equal ratios and integer multiples.

Top module: `coinc_sync_gen`

## Requirements
- R1: While `rst_n` is low, `out_a` and `out_c` are 0 and `sync_n` is 1. The ratios on `ratio_a` and `ratio_c` are captured in these cycles.
- R2: A ratio is read as 6-bit unsigned. A captured value below 2 acts as 2, and a value above 32 acts as 32.
- R3: Once running, each output clock has a period of N reference cycles, where N is its ratio. It is high for the first floor(N/2) cycles of each period. Cycle 0 is the first running cycle, and in that cycle both clocks go high together.
- R4: After reset is released, `out_a` and `out_c` stay 0 and `sync_n` stays 1 until the LCM is known. Both clocks first go high within NA+NC+2 reference cycles of the release.
- R5: For unequal ratios, let P be the smaller ratio and L the LCM. `sync_n` is 0 exactly in the last P cycles of each L-cycle interval, so each low pulse lasts P cycles.
- R6: `sync_n` returns to 1 in the same cycle in which both `out_a` and `out_c` rise. Every shared rise after the first running cycle comes with such a return.
- R7: Exactly one low pulse of `sync_n` occurs in each L-cycle interval, for integer-multiple ratio pairs as well as for other pairs.
- R8: For equal ratios N, `sync_n` is 1 for the first floor(N/2) cycles of each period and 0 for the remaining ceil(N/2) cycles. The strobe therefore still pulses in every period.
- R9: A change of `ratio_a` or `ratio_c` while `rst_n` is high has no effect on any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset; ratios are sampled while it is low |
| ratio_a | input | 6 | Divide ratio for `out_a` |
| ratio_c | input | 6 | Divide ratio for `out_c` |
| out_a | output | 1 | First divided clock |
| out_c | output | 1 | Second divided clock |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The assertions check the registered ratio copies, not the input pins. They assume these copies change only under reset, and that every reset lasts at least one full clock cycle so that the capture happens. The bench holds each reset for several cycles with stable ratios. It changes the ratio pins outside reset only in the scenario that probes R9, and there the captured ratios must stay unchanged. Pulse-width checks assume at least one full LCM interval elapses between resets. Every bench scenario runs for three intervals before it resets again.

// File: rtl/coinc_pkg.sv
// Package: shared limits and state type for the coincidence sync generator.
// Assumes ratios are carried as unsigned values of DIV_W bits.
package coinc_pkg;
    localparam int DIV_W_DEF   = 6;
    localparam int DIV_MIN_DEF = 2;
    localparam int DIV_MAX_DEF = 32;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_CALC = 2'd1,
        LS_DONE = 2'd2
    } lcm_state_t;
endpackage

// File: rtl/lcm_unit.sv
// Module: lcm_unit
// Finds the least common multiple of two ratios by stepping two running
// multiples, always advancing the smaller one, until they meet.
// Assumes both ratios are nonzero and stable from the cycle after reset.
// The search takes at most div_a + div_c cycles.
module lcm_unit
    import coinc_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    parameter int LCM_W = 2 * DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_c,
    output logic [LCM_W-1:0] lcm,
    output logic             done
);
    localparam int PAD_W = LCM_W - DIV_W;

    lcm_state_t       state;
    logic [LCM_W-1:0] mult_a;
    logic [LCM_W-1:0] mult_c;
    logic [LCM_W-1:0] step_a;
    logic [LCM_W-1:0] step_c;

    // Widen the ratios to the multiple width.
    always_comb begin
        step_a = {{PAD_W{1'b0}}, div_a};
        step_c = {{PAD_W{1'b0}}, div_c};
    end

    // Search sequencer: load, advance the lagging multiple, stop on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LS_IDLE;
            mult_a <= '0;
            mult_c <= '0;
        end else begin
            case (state)
                LS_IDLE: begin
                    mult_a <= step_a;
                    mult_c <= step_c;
                    state  <= LS_CALC;
                end
                LS_CALC: begin
                    if (mult_a == mult_c) begin
                        state <= LS_DONE;
                    end else if (mult_a < mult_c) begin
                        mult_a <= mult_a + step_a;
                    end else begin
                        mult_c <= mult_c + step_c;
                    end
                end
                default: begin
                    state <= LS_DONE;
                end
            endcase
        end
    end

    // Result and completion flag.
    always_comb begin
        lcm  = mult_a;
        done = (state == LS_DONE);
    end
endmodule

// File: rtl/clk_divider.sv
// Module: clk_divider
// Integer divider for one output clock. Its phase counter restarts at zero
// when run rises. The output is high for the first floor(div/2) counts.
// Assumes div >= 2 and stable while run is high.
module clk_divider
    import coinc_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             clk_out
);
    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] high_len;

    // Terminal count and high-phase length.
    always_comb begin
        last     = div - 1'b1;
        high_len = div >> 1;
    end

    // Phase counter, modulo div, held at zero until running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == last) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Output waveform decode, low while idle.
    always_comb begin
        clk_out = run && (phase < high_len);
    end
endmodule

// File: rtl/sync_ctrl.sv
// Module: sync_ctrl
// Master counter modulo the LCM and the active-low strobe decode. For
// unequal ratios the strobe is low in the last p counts. For equal ratios
// (lcm == p) it is low in the second half of each period.
// Assumes lcm >= p >= 2 and stable while run is high.
module sync_ctrl
    import coinc_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF,
    parameter int LCM_W = 2 * DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LCM_W-1:0] lcm,
    input  logic [DIV_W-1:0] p_min,
    input  logic             same,
    output logic             sync_n
);
    localparam int PAD_W = LCM_W - DIV_W;

    logic [LCM_W-1:0] master;
    logic [LCM_W-1:0] thresh;
    logic [LCM_W-1:0] half;
    logic [LCM_W-1:0] last;

    // Window boundaries derived from the LCM and the faster ratio.
    always_comb begin
        thresh = lcm - {{PAD_W{1'b0}}, p_min};
        half   = {{PAD_W{1'b0}}, (p_min >> 1)};
        last   = lcm - 1'b1;
    end

    // Master counter, modulo lcm, zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            master <= '0;
        end else if (master == last) begin
            master <= '0;
        end else begin
            master <= master + 1'b1;
        end
    end

    // Strobe decode: high while idle, low in the warning window.
    always_comb begin
        if (!run) begin
            sync_n = 1'b1;
        end else if (same) begin
            sync_n = (master < half);
        end else begin
            sync_n = (master < thresh);
        end
    end
endmodule

// File: rtl/coinc_sync_gen.sv
// Module: coinc_sync_gen (top)
// Captures and clamps two ratios during reset, finds their LCM, then runs
// two dividers and the strobe controller from a common start.
// Assumes rst_n is synchronous and held for at least one clock.
module coinc_sync_gen
    import coinc_pkg::*;
#(
    parameter int DIV_W   = DIV_W_DEF,
    parameter int DIV_MIN = DIV_MIN_DEF,
    parameter int DIV_MAX = DIV_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio_a,
    input  logic [DIV_W-1:0] ratio_c,
    output logic             out_a,
    output logic             out_c,
    output logic             sync_n
);
    localparam int LCM_W = 2 * DIV_W;
    localparam int N_CH  = 2;
    localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

    logic [N_CH-1:0][DIV_W-1:0] ratio_in;
    logic [N_CH-1:0][DIV_W-1:0] div_q;
    logic [N_CH-1:0]            clk_q;
    logic [LCM_W-1:0]           lcm;
    logic                       run;
    logic [DIV_W-1:0]           p_min;
    logic                       same;

    // Gather the ratio pins into one vector.
    always_comb begin
        ratio_in[0] = ratio_a;
        ratio_in[1] = ratio_c;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // Ratio capture with clamping, only while reset is held.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                if (ratio_in[ch] < LO) begin
                    div_q[ch] <= LO;
                end else if (ratio_in[ch] > HI) begin
                    div_q[ch] <= HI;
                end else begin
                    div_q[ch] <= ratio_in[ch];
                end
            end
        end

        clk_divider #(
            .DIV_W (DIV_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .div     (div_q[ch]),
            .clk_out (clk_q[ch])
        );
    end

    // Faster ratio and equality flag.
    always_comb begin
        p_min = (div_q[0] < div_q[1]) ? div_q[0] : div_q[1];
        same  = (div_q[0] == div_q[1]);
    end

    lcm_unit #(
        .DIV_W (DIV_W),
        .LCM_W (LCM_W)
    ) u_lcm (
        .clk   (clk),
        .rst_n (rst_n),
        .div_a (div_q[0]),
        .div_c (div_q[1]),
        .lcm   (lcm),
        .done  (run)
    );

    sync_ctrl #(
        .DIV_W (DIV_W),
        .LCM_W (LCM_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .lcm    (lcm),
        .p_min  (p_min),
        .same   (same),
        .sync_n (sync_n)
    );

    // Output assignment.
    always_comb begin
        out_a = clk_q[0];
        out_c = clk_q[1];
    end
endmodule

// File: rtl/coinc_sync_chk.sv
// Module: coinc_sync_chk
// Assertion checker bound into coinc_sync_gen. Checks the idle state, the
// strobe alignment to shared rising edges, the pulse width and ratio
// stability while running.
module coinc_sync_chk #(
    parameter int DIV_W   = 6,
    parameter int LCM_W   = 12,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [DIV_W-1:0] div_a,
    input logic [DIV_W-1:0] div_c,
    input logic             out_a,
    input logic             out_c,
    input logic             sync_n
);
    logic [LCM_W-1:0] low_len;
    logic [LCM_W-1:0] exp_len;
    logic [DIV_W-1:0] p;

    // Expected pulse width from the captured ratios (R5, R8).
    always_comb begin
        p = (div_a < div_c) ? div_a : div_c;
        if (div_a == div_c) begin
            exp_len = LCM_W'(p - (p >> 1));
        end else begin
            exp_len = LCM_W'(p);
        end
    end

    // Length of the current low run of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_n) begin
            low_len <= '0;
        end else begin
            low_len <= low_len + 1'b1;
        end
    end

    // R2: captured ratios stay in range once running.
    always_ff @(posedge clk) begin
        if (rst_n && run) begin
            a_r2_ratio_range: assert (div_a >= DIV_MW && div_a <= DIV_XW &&
                                      div_c >= DIV_MW && div_c <= DIV_XW)
                else $error("a_r2_ratio_range");
        end
    end
    localparam logic [DIV_W-1:0] DIV_MW = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] DIV_XW = DIV_W'(DIV_MAX);

    // R4: outputs idle until the LCM search finishes.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (sync_n && !out_a && !out_c));

    // R6: strobe returns high only where both clocks are high.
    a_r6_rise_on_coincidence: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (out_a && out_c));

    // R6: every shared rise while running brings the strobe back high.
    a_r6_coincidence_has_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $rose(out_a) && $rose(out_c)) |-> $rose(sync_n));

    // R5 / R8: low pulse width equals the expected length.
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(sync_n)) |-> (low_len == exp_len));

    // R9: captured ratios are frozen while running.
    a_r9_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(div_a) && $stable(div_c)));
endmodule

bind coinc_sync_gen coinc_sync_chk #(
    .DIV_W   (DIV_W),
    .LCM_W   (LCM_W),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .div_a  (div_q[0]),
    .div_c  (div_q[1]),
    .out_a  (out_a),
    .out_c  (out_c),
    .sync_n (sync_n)
);

// File: tb/coinc_sync_gen_test.sv
// Bench: directed scenarios, each task applies one ratio pair and checks
// its own results against a model built from the requirements.
module coinc_sync_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ratio_a = 6'd2;
    logic [5:0] ratio_c = 6'd3;
    logic       out_a;
    logic       out_c;
    logic       sync_n;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    coinc_sync_gen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_a (ratio_a),
        .ratio_c (ratio_c),
        .out_a   (out_a),
        .out_c   (out_c),
        .sync_n  (sync_n)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clampr(input int r);
        if (r < 2) return 2;
        if (r > 32) return 32;
        return r;
    endfunction

    function automatic int gcd(input int x, input int y);
        int a = x;
        int b = y;
        while (b != 0) begin
            int t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // One scenario: reset with (ra, rc), optional pin change mid-run.
    task automatic run_case(input int ra, input int rc, input bit change_mid,
                            input string tag);
        int na = clampr(ra);
        int nc = clampr(rc);
        int L = na * nc / gcd(na, nc);
        int P = (na < nc) ? na : nc;
        bit eq = (na == nc);
        int expw = eq ? (P - P / 2) : P;
        int wait_n = 0;
        int bad_hold = 0;
        int bad_clk = 0;
        int bad_sync = 0;
        int bad_w = 0;
        int bad_co = 0;
        int rises = 0;
        int lowrun = 0;
        bit ps = 1'b1;
        bit pa = 1'b0;
        bit pc = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        ratio_a = 6'(ra);
        ratio_c = 6'(rc);
        repeat (3) @(negedge clk);
        check(out_a == 1'b0 && out_c == 1'b0 && sync_n == 1'b1, "R1",
              {tag, " reset state a,c,s"}, {out_a, out_c, sync_n}, 3'b001);
        rst_n = 1'b1;
        // R4: wait for the common start, outputs idle meanwhile.
        forever begin
            @(negedge clk);
            wait_n++;
            if (out_a) break;
            if (out_c || !sync_n) bad_hold++;
            if (wait_n > na + nc + 2) break;
        end
        check(wait_n <= na + nc + 2, "R4", {tag, " start latency"}, wait_n, na + nc + 2);
        check(bad_hold == 0, "R4", {tag, " idle hold violations"}, bad_hold, 0);
        for (int t = 0; t < 3 * L; t++) begin
            int m = t % L;
            bit ea = (t % na) < (na / 2);
            bit ec = (t % nc) < (nc / 2);
            bit es = eq ? (m < P / 2) : (m < L - P);
            if (t > 0) @(negedge clk);
            if (out_a != ea || out_c != ec) bad_clk++;
            if (sync_n != es) bad_sync++;
            if (!sync_n) lowrun++;
            if (sync_n && !ps) begin
                rises++;
                if (lowrun != expw) bad_w++;
                if (!(out_a && out_c && !pa && !pc)) bad_co++;
                lowrun = 0;
            end
            ps = sync_n;
            pa = out_a;
            pc = out_c;
            if (change_mid && t == L) begin
                ratio_a = 6'd9;
                ratio_c = 6'd9;
            end
        end
        check(bad_clk == 0, change_mid ? "R9" : "R3", {tag, " clock waveform mismatches"},
              bad_clk, 0);
        check(bad_sync == 0, eq ? "R8" : "R5", {tag, " strobe waveform mismatches"},
              bad_sync, 0);
        check(bad_w == 0, eq ? "R8" : "R5", {tag, " pulse width errors"}, bad_w, 0);
        check(bad_co == 0, "R6", {tag, " rise not on shared edge"}, bad_co, 0);
        check(rises == 2, "R7", {tag, " pulses in three intervals after start"}, rises, 2);
    endtask

    task automatic t_coprime();       run_case(2, 3, 1'b0, "coprime 2/3");   endtask
    task automatic t_coprime_swap();  run_case(3, 2, 1'b0, "coprime 3/2");   endtask
    task automatic t_multiple();      run_case(4, 8, 1'b0, "multiple 4/8");  endtask
    task automatic t_multiple_swap(); run_case(8, 4, 1'b0, "multiple 8/4");  endtask
    task automatic t_shared_factor(); run_case(6, 9, 1'b0, "shared 6/9");    endtask
    task automatic t_equal_odd();     run_case(5, 5, 1'b0, "equal 5/5 R8");  endtask
    task automatic t_equal_min();     run_case(2, 2, 1'b0, "equal 2/2 R8");  endtask
    task automatic t_wide();          run_case(7, 32, 1'b0, "wide 7/32");    endtask
    task automatic t_largest();       run_case(31, 32, 1'b0, "largest 31/32"); endtask
    task automatic t_clamp();         run_case(0, 40, 1'b0, "clamp 0/40 R2"); endtask
    task automatic t_clamp_low();     run_case(1, 3, 1'b0, "clamp 1/3 R2"); endtask
    task automatic t_change();        run_case(3, 5, 1'b1, "change 3/5 R9"); endtask

    initial begin
        t_coprime();
        t_coprime_swap();
        t_multiple();
        t_multiple_swap();
        t_shared_factor();
        t_equal_odd();
        t_equal_min();
        t_wide();
        t_largest();
        t_clamp();
        t_clamp_low();
        t_change();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule